// File: doc/BRIEF.md
# Programmable Video Timing Engine with Border Fill

This block generates the raster timing for a display link. One counter tracks the pixel-clock offset from the top of the frame and a second tracks the horizontal position within the current line. Register-programmed limits compared against those counters produce horizontal sync, vertical sync and data enable. All vertical limits are written as absolute pixel-clock offsets, computed as line number times line length plus any line skew, so a sync edge or window edge may fall anywhere within a line.

An optional inner active window can be enabled separately in each axis. It must lie inside the display region. Display pixels outside the enabled window carry a programmable border colour. Pixels inside the window carry the source pixel. If the source cannot deliver a pixel, they carry a programmable underflow colour. A single-cycle fetch pulse can be placed at any frame offset. Frame and line counts can be read back over the register port.

Software writes a program copy of every timing register. While the engine runs, the live copy that drives the comparators is refreshed from the program copy only on the last pixel of a frame. While the engine is stopped, the live copy follows the program copy continuously.

Top module: `disp_timing_gen`

## Requirements
- R1: HCTL (word 2) holds the line length in clocks in bits 31:16 and the sync width in bits 15:0. Raw hsync is high while the horizontal position is below the sync width. The position wraps to zero after line length minus one.
- R2: VTOT (word 3) holds the frame length in pixel clocks and VPW (word 4) holds the vertical sync width in pixel clocks. The frame offset advances by one each clock, wraps to zero after VTOT minus one, and raw vsync is high while the offset is below VPW.
- R3: Raw data enable is high when the horizontal position lies within DISPH (word 5: last column in bits 31:16, first column in bits 15:0) and the frame offset lies within DVS..DVE (words 6 and 7), both bounds inclusive.
- R4: CFG (word 1) bit 29 enables the horizontal window ACTH (word 8, packed like DISPH) and bit 30 enables the vertical window AVS..AVE (words 9 and 10). A display pixel outside an enabled window outputs BORDER (word 11).
- R5: pix_req is high exactly for display pixels inside every enabled window. Such a pixel outputs src_pixel when src_valid is high and UNDER (word 12) otherwise. Outside the display region pix_out is zero.
- R6: POL (word 13) bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable.
- R7: With CFG bit 31 set, fetch_pulse is high for the one clock whose frame offset equals FETCH (word 14). It is never high when that bit is clear.
- R8: Word 15 reads the number of completed frames and word 16 reads the line index within the current frame. Both read zero while the engine is stopped.
- R9: A write to words 1 to 14 while the engine runs leaves the current frame untouched and takes effect from the first clock of the next frame.
- R10: ENABLE (word 0) bit 0 starts the engine. While it is clear, the counters hold zero, hsync, vsync and de sit at their inactive levels as set by POL, pix_out is zero, and pix_req and fetch_pulse are low.
- R11: Words 0 to 14 read back the last value written, with unimplemented bits read as zero. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_pixel | input | PIX_W | Pixel from the upstream source |
| src_valid | input | 1 | Source pixel is available this clock |
| pix_req | output | 1 | Clock lies in the active window |
| pix_out | output | PIX_W | Pixel driven to the link |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| fetch_pulse | output | 1 | Programmable frame-position pulse |

## Verification
Frame and line positions are internal, so a wrong counter shows at the ports only when a comparator edge moves. A slipped position shifts hsync, the data-enable window or the fetch pulse within the same line, and the per-clock comparison catches that on the first affected clock. A missed or premature live-copy refresh shows as a whole frame timed with the old or new settings, visible from the first clock after the wrap. Readback of the frame and line counts exposes counter drift even when the sync outputs happen to agree.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

   // register word addresses
   localparam logic [31:0] A_ENABLE = 32'd0;
   localparam logic [31:0] A_CFG    = 32'd1;
   localparam logic [31:0] A_HCTL   = 32'd2;
   localparam logic [31:0] A_VTOT   = 32'd3;
   localparam logic [31:0] A_VPW    = 32'd4;
   localparam logic [31:0] A_DISPH  = 32'd5;
   localparam logic [31:0] A_DVS    = 32'd6;
   localparam logic [31:0] A_DVE    = 32'd7;
   localparam logic [31:0] A_ACTH   = 32'd8;
   localparam logic [31:0] A_AVS    = 32'd9;
   localparam logic [31:0] A_AVE    = 32'd10;
   localparam logic [31:0] A_BORDER = 32'd11;
   localparam logic [31:0] A_UNDER  = 32'd12;
   localparam logic [31:0] A_POL    = 32'd13;
   localparam logic [31:0] A_FETCH  = 32'd14;
   localparam logic [31:0] A_FRAMES = 32'd15;
   localparam logic [31:0] A_LINES  = 32'd16;

   localparam int NUM_SYNC = 3;  // hsync, vsync, de

   typedef struct packed {
      logic        fetch_en;
      logic        vwin_en;
      logic        hwin_en;
      logic [2:0]  pol;
      logic [15:0] htot;
      logic [15:0] hpw;
      logic [15:0] dhs;
      logic [15:0] dhe;
      logic [15:0] ahs;
      logic [15:0] ahe;
      logic [31:0] vtot;
      logic [31:0] vpw;
      logic [31:0] dvs;
      logic [31:0] dve;
      logic [31:0] avs;
      logic [31:0] ave;
      logic [31:0] fetch_at;
   } tgen_cfg_t;

endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
   import tgen_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PIX_W  = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [CNT_W-1:0]  frame_cnt,
   input  logic [CNT_W-1:0]  line_cnt,
   input  logic              frame_wrap,
   output logic              eng_en,
   output tgen_cfg_t         live,
   output logic [PIX_W-1:0]  live_border,
   output logic [PIX_W-1:0]  live_under
);

   tgen_cfg_t        prog;
   logic [PIX_W-1:0] prog_border;
   logic [PIX_W-1:0] prog_under;
   logic [31:0]      a32;
   logic             refresh;

   assign a32     = 32'(reg_addr);
   assign refresh = !eng_en || frame_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog        <= '0;
         live        <= '0;
         prog_border <= '0;
         prog_under  <= '0;
         live_border <= '0;
         live_under  <= '0;
         eng_en      <= 1'b0;
      end else begin
         if (refresh) begin
            live        <= prog;
            live_border <= prog_border;
            live_under  <= prog_under;
         end
         if (reg_wr) begin
            case (a32)
               A_ENABLE: eng_en <= reg_wdata[0];
               A_CFG: begin
                  prog.fetch_en <= reg_wdata[31];
                  prog.vwin_en  <= reg_wdata[30];
                  prog.hwin_en  <= reg_wdata[29];
               end
               A_HCTL: begin
                  prog.htot <= reg_wdata[31:16];
                  prog.hpw  <= reg_wdata[15:0];
               end
               A_VTOT:  prog.vtot <= reg_wdata;
               A_VPW:   prog.vpw  <= reg_wdata;
               A_DISPH: begin
                  prog.dhe <= reg_wdata[31:16];
                  prog.dhs <= reg_wdata[15:0];
               end
               A_DVS:   prog.dvs <= reg_wdata;
               A_DVE:   prog.dve <= reg_wdata;
               A_ACTH: begin
                  prog.ahe <= reg_wdata[31:16];
                  prog.ahs <= reg_wdata[15:0];
               end
               A_AVS:    prog.avs     <= reg_wdata;
               A_AVE:    prog.ave     <= reg_wdata;
               A_BORDER: prog_border  <= reg_wdata[PIX_W-1:0];
               A_UNDER:  prog_under   <= reg_wdata[PIX_W-1:0];
               A_POL:    prog.pol     <= reg_wdata[2:0];
               A_FETCH:  prog.fetch_at <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (a32)
         A_ENABLE: reg_rdata = {31'd0, eng_en};
         A_CFG:    reg_rdata = {prog.fetch_en, prog.vwin_en, prog.hwin_en, 29'd0};
         A_HCTL:   reg_rdata = {prog.htot, prog.hpw};
         A_VTOT:   reg_rdata = prog.vtot;
         A_VPW:    reg_rdata = prog.vpw;
         A_DISPH:  reg_rdata = {prog.dhe, prog.dhs};
         A_DVS:    reg_rdata = prog.dvs;
         A_DVE:    reg_rdata = prog.dve;
         A_ACTH:   reg_rdata = {prog.ahe, prog.ahs};
         A_AVS:    reg_rdata = prog.avs;
         A_AVE:    reg_rdata = prog.ave;
         A_BORDER: reg_rdata = 32'(prog_border);
         A_UNDER:  reg_rdata = 32'(prog_under);
         A_POL:    reg_rdata = {29'd0, prog.pol};
         A_FETCH:  reg_rdata = prog.fetch_at;
         A_FRAMES: reg_rdata = eng_en ? 32'(frame_cnt) : 32'd0;
         A_LINES:  reg_rdata = eng_en ? 32'(line_cnt) : 32'd0;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tgen_counters.sv
module tgen_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_en,
   input  logic [15:0]      htot,
   input  logic [31:0]      vtot,
   output logic [31:0]      fpos,
   output logic [15:0]      hpos,
   output logic [CNT_W-1:0] line_cnt,
   output logic [CNT_W-1:0] frame_cnt,
   output logic             frame_wrap
);

   logic line_end;

   // a frame length of 0 or 1 collapses to a single-clock frame
   assign frame_wrap = eng_en && ((vtot <= 32'd1) || (fpos >= vtot - 32'd1));
   assign line_end   = ({1'b0, hpos} + 17'd1) >= {1'b0, htot};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpos      <= '0;
         hpos      <= '0;
         line_cnt  <= '0;
         frame_cnt <= '0;
      end else if (!eng_en) begin
         fpos      <= '0;
         hpos      <= '0;
         line_cnt  <= '0;
         frame_cnt <= '0;
      end else if (frame_wrap) begin
         fpos      <= '0;
         hpos      <= '0;
         line_cnt  <= '0;
         frame_cnt <= frame_cnt + 1'b1;
      end else begin
         fpos <= fpos + 32'd1;
         if (line_end) begin
            hpos     <= '0;
            line_cnt <= line_cnt + 1'b1;
         end else begin
            hpos <= hpos + 16'd1;
         end
      end
   end

endmodule

// File: rtl/tgen_pixel.sv
module tgen_pixel
   import tgen_pkg::*;
#(
   parameter int PIX_W = 24
) (
   input  logic             eng_en,
   input  logic [31:0]      fpos,
   input  logic [15:0]      hpos,
   input  logic [15:0]      hpw,
   input  logic [31:0]      vpw,
   input  logic [15:0]      dhs,
   input  logic [15:0]      dhe,
   input  logic [31:0]      dvs,
   input  logic [31:0]      dve,
   input  logic             hwin_en,
   input  logic             vwin_en,
   input  logic [15:0]      ahs,
   input  logic [15:0]      ahe,
   input  logic [31:0]      avs,
   input  logic [31:0]      ave,
   input  logic             fetch_en,
   input  logic [31:0]      fetch_at,
   input  logic [2:0]       pol,
   input  logic [PIX_W-1:0] border,
   input  logic [PIX_W-1:0] under,
   input  logic [PIX_W-1:0] src_pixel,
   input  logic             src_valid,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [PIX_W-1:0] pix_out,
   output logic             pix_req,
   output logic             fetch_pulse,
   output logic             de_raw
);

   logic in_dh, in_dv, in_ah, in_av, act;
   logic [NUM_SYNC-1:0] raw_sync;
   logic [NUM_SYNC-1:0] out_sync;

   assign in_dh = (hpos >= dhs) && (hpos <= dhe);
   assign in_dv = (fpos >= dvs) && (fpos <= dve);
   assign in_ah = !hwin_en || ((hpos >= ahs) && (hpos <= ahe));
   assign in_av = !vwin_en || ((fpos >= avs) && (fpos <= ave));

   assign de_raw  = eng_en && in_dh && in_dv;
   assign act     = de_raw && in_ah && in_av;
   assign pix_req = act;

   always_comb begin
      if (!de_raw)        pix_out = '0;
      else if (!act)      pix_out = border;
      else if (src_valid) pix_out = src_pixel;
      else                pix_out = under;
   end

   assign fetch_pulse = eng_en && fetch_en && (fpos == fetch_at);

   assign raw_sync[0] = hpos < hpw;
   assign raw_sync[1] = fpos < vpw;
   assign raw_sync[2] = de_raw;

   // per-signal polarity stage; stopped engine parks each at its idle level
   for (genvar g = 0; g < NUM_SYNC; g++) begin : g_pol
      assign out_sync[g] = eng_en ? (raw_sync[g] ^ pol[g]) : pol[g];
   end

   assign hsync = out_sync[0];
   assign vsync = out_sync[1];
   assign de    = out_sync[2];

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import tgen_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PIX_W  = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [PIX_W-1:0]  src_pixel,
   input  logic              src_valid,
   output logic              pix_req,
   output logic [PIX_W-1:0]  pix_out,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              fetch_pulse
);

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("disp_timing_gen: ADDR_W must be 5..16");
   end
   if (PIX_W < 1 || PIX_W > 32) begin : g_bad_pix
      $error("disp_timing_gen: PIX_W must be 1..32");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("disp_timing_gen: CNT_W must be 1..32");
   end

   tgen_cfg_t        live_cfg;
   logic [PIX_W-1:0] live_border;
   logic [PIX_W-1:0] live_under;
   logic             eng_en;
   logic             frame_wrap;
   logic [31:0]      fpos;
   logic [15:0]      hpos;
   logic [CNT_W-1:0] line_cnt;
   logic [CNT_W-1:0] frame_cnt;
   logic             de_raw;

   tgen_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .frame_cnt   (frame_cnt),
      .line_cnt    (line_cnt),
      .frame_wrap  (frame_wrap),
      .eng_en      (eng_en),
      .live        (live_cfg),
      .live_border (live_border),
      .live_under  (live_under)
   );

   tgen_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .eng_en     (eng_en),
      .htot       (live_cfg.htot),
      .vtot       (live_cfg.vtot),
      .fpos       (fpos),
      .hpos       (hpos),
      .line_cnt   (line_cnt),
      .frame_cnt  (frame_cnt),
      .frame_wrap (frame_wrap)
   );

   tgen_pixel #(.PIX_W(PIX_W)) u_pix (
      .eng_en      (eng_en),
      .fpos        (fpos),
      .hpos        (hpos),
      .hpw         (live_cfg.hpw),
      .vpw         (live_cfg.vpw),
      .dhs         (live_cfg.dhs),
      .dhe         (live_cfg.dhe),
      .dvs         (live_cfg.dvs),
      .dve         (live_cfg.dve),
      .hwin_en     (live_cfg.hwin_en),
      .vwin_en     (live_cfg.vwin_en),
      .ahs         (live_cfg.ahs),
      .ahe         (live_cfg.ahe),
      .avs         (live_cfg.avs),
      .ave         (live_cfg.ave),
      .fetch_en    (live_cfg.fetch_en),
      .fetch_at    (live_cfg.fetch_at),
      .pol         (live_cfg.pol),
      .border      (live_border),
      .under       (live_under),
      .src_pixel   (src_pixel),
      .src_valid   (src_valid),
      .hsync       (hsync),
      .vsync       (vsync),
      .de          (de),
      .pix_out     (pix_out),
      .pix_req     (pix_req),
      .fetch_pulse (fetch_pulse),
      .de_raw      (de_raw)
   );

endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk
   import tgen_pkg::*;
#(
   parameter int PIX_W = 24,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eng_en,
   input logic [31:0]      fpos,
   input logic [15:0]      hpos,
   input logic [15:0]      htot,
   input logic [CNT_W-1:0] frame_cnt,
   input tgen_cfg_t        live_cfg,
   input logic [PIX_W-1:0] live_border,
   input logic             de_raw,
   input logic             pix_req,
   input logic             src_valid,
   input logic [PIX_W-1:0] src_pixel,
   input logic [PIX_W-1:0] pix_out,
   input logic             fetch_pulse
);

   // R1: horizontal position stays inside the programmed line
   assert_hpos_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && htot != 16'd0) |-> (hpos < htot));

   // R2: frame offset advances by one each clock except on a wrap
   assert_fpos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && $past(eng_en) && fpos != 32'd0) |-> (fpos == $past(fpos) + 32'd1));

   // R4: display pixel outside the active window carries border colour
   assert_border_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (de_raw && !pix_req) |-> (pix_out == live_border));

   // R5: requested and delivered pixel passes through unchanged
   assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && src_valid) |-> (pix_out == src_pixel));

   // R5: requests only inside the data-enable region
   assert_req_in_display_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |-> de_raw);

   // R8: frame count steps exactly when the offset returns to zero
   assert_frame_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && $past(eng_en) && fpos == 32'd0 && $past(fpos) != 32'd0)
      |-> (frame_cnt == $past(frame_cnt) + 1'b1));

   // R9: live settings hold for the whole frame
   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && $past(eng_en) && fpos != 32'd0) |-> (live_cfg == $past(live_cfg)));

   // R10: stopped engine drives nothing
   assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_en |-> (pix_out == '0 && !pix_req && !fetch_pulse));

endmodule

bind disp_timing_gen disp_timing_gen_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .eng_en      (eng_en),
   .fpos        (fpos),
   .hpos        (hpos),
   .htot        (live_cfg.htot),
   .frame_cnt   (frame_cnt),
   .live_cfg    (live_cfg),
   .live_border (live_border),
   .de_raw      (de_raw),
   .pix_req     (pix_req),
   .src_valid   (src_valid),
   .src_pixel   (src_pixel),
   .pix_out     (pix_out),
   .fetch_pulse (fetch_pulse)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;

   localparam int ADDR_W = 5;
   localparam int PIX_W  = 24;
   localparam int CNT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [PIX_W-1:0]  src_pixel = '0;
   logic              src_valid = 1'b0;
   logic              pix_req;
   logic [PIX_W-1:0]  pix_out;
   logic              hsync, vsync, de, fetch_pulse;

   always #10 clk = ~clk;  // 50 MHz

   disp_timing_gen #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pixel(src_pixel),
      .src_valid(src_valid), .pix_req(pix_req), .pix_out(pix_out),
      .hsync(hsync), .vsync(vsync), .de(de), .fetch_pulse(fetch_pulse)
   );

   // bench model state
   logic [31:0] prog [0:14];
   logic [31:0] live [0:14];
   logic        men;
   logic [31:0] mf;
   logic [15:0] mh;
   logic [15:0] mline, mframe;
   logic [31:0] stage [1:14];

   int    vectors = 0;
   int    fails = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string phase = "";

   function automatic logic [31:0] wmask(int a, logic [31:0] d);
      case (a)
         0:       return d & 32'h1;
         1:       return d & 32'hE000_0000;
         11, 12:  return d & 32'h00FF_FFFF;
         13:      return d & 32'h7;
         default: return d;
      endcase
   endfunction

   task automatic cmp(string req, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s cyc=%0d: got %h expected %h", req, phase, cyc, got, exp);
      end
   endtask

   task automatic check_outputs(int rd);
      logic [15:0] ht, hpw, dhs, dhe, ahs, ahe;
      logic        d, a, hs, vs;
      logic [2:0]  pl;
      logic [23:0] ep;
      logic [31:0] er;
      hpw = live[2][15:0];
      dhs = live[5][15:0];  dhe = live[5][31:16];
      ahs = live[8][15:0];  ahe = live[8][31:16];
      pl  = live[13][2:0];
      d  = men && mh >= dhs && mh <= dhe && mf >= live[6] && mf <= live[7];
      a  = d && (!live[1][29] || (mh >= ahs && mh <= ahe))
             && (!live[1][30] || (mf >= live[9] && mf <= live[10]));
      hs = mh < hpw;
      vs = mf < live[4];
      ep = !d ? 24'd0 : !a ? live[11][23:0] : src_valid ? src_pixel : live[12][23:0];
      cmp("R1 R6 hsync", {31'd0, hsync}, {31'd0, men ? (hs ^ pl[0]) : pl[0]});
      cmp("R2 R6 vsync", {31'd0, vsync}, {31'd0, men ? (vs ^ pl[1]) : pl[1]});
      cmp("R3 R6 de",    {31'd0, de},    {31'd0, men ? (d ^ pl[2]) : pl[2]});
      cmp("R4 R5 pix_out", {8'd0, pix_out}, {8'd0, ep});
      cmp("R5 pix_req", {31'd0, pix_req}, {31'd0, a});
      cmp("R7 fetch_pulse", {31'd0, fetch_pulse},
          {31'd0, men && live[1][31] && mf == live[14]});
      if (rd == 15)      begin er = men ? {16'd0, mframe} : 32'd0; cmp("R8 frames", reg_rdata, er); end
      else if (rd == 16) begin er = men ? {16'd0, mline}  : 32'd0; cmp("R8 lines",  reg_rdata, er); end
      else if (rd == 0)  cmp("R11 enable readback", reg_rdata, {31'd0, men});
      else               cmp("R11 readback", reg_rdata, prog[rd]);
      ht = live[2][31:16];
      if (ht == 16'hFFFF) $display("note: long line");
   endtask

   task automatic model_edge(bit wr, int a, logic [31:0] d);
      bit old_en, wrap;
      old_en = men;
      wrap = old_en && (mf >= live[3] - 32'd1);
      if (!old_en) begin
         mf = 0; mh = 0; mline = 0; mframe = 0;
      end else if (wrap) begin
         mf = 0; mh = 0; mline = 0; mframe = mframe + 16'd1;
      end else begin
         mf = mf + 32'd1;
         if ({16'd0, mh} + 32'd1 >= {16'd0, live[2][31:16]}) begin
            mh = 0; mline = mline + 16'd1;
         end else mh = mh + 16'd1;
      end
      if (!old_en || wrap)
         for (int i = 1; i <= 14; i++) live[i] = prog[i];
      if (wr && a <= 14) begin
         if (a == 0) men = d[0];
         else prog[a] = wmask(a, d);
      end
   endtask

   task automatic do_cycle(bit wr, int a, logic [31:0] d);
      int rd;
      rd = wr ? a : (cyc % 17);
      reg_wr    = wr;
      reg_addr  = ADDR_W'(rd);
      reg_wdata = d;
      src_valid = ($urandom % 4) != 0;
      src_pixel = 24'($urandom);
      #1;
      check_outputs(rd);
      @(posedge clk);
      model_edge(wr, a, d);
      cyc++;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) do_cycle(1'b0, 0, 32'd0);
   endtask

   // compute and write a full timing set from porch and size values
   task automatic program_set(int hp, int hbp, int w, int fp, int vp, int vbp,
                              int hgt, int vfp, int skew, int xres, int yres,
                              logic [2:0] pl, bit fen);
      int ht, lines, dvs, dve, dhs, dhe;
      logic [31:0] cfgv;
      ht = hp + hbp + w + fp;
      lines = vp + vbp + hgt + vfp;
      dhs = hbp + hp;
      dhe = ht - fp - 1;
      dvs = (vp + vbp) * ht + skew;
      dve = (lines - vfp) * ht + skew - 1;
      cfgv = {fen, 31'd0};
      stage[8] = 0; stage[9] = 0; stage[10] = 0;
      if (xres != w) begin
         cfgv[29] = 1'b1;
         stage[8] = ((dhs + xres - 1) << 16) | dhs;
      end
      if (yres != hgt) begin
         cfgv[30] = 1'b1;
         stage[9]  = dvs;
         stage[10] = dvs + yres * ht - 1;
      end
      stage[1]  = cfgv;
      stage[2]  = (ht << 16) | hp;
      stage[3]  = lines * ht;
      stage[4]  = vp * ht;
      stage[5]  = (dhe << 16) | dhs;
      stage[6]  = dvs;
      stage[7]  = dve;
      stage[11] = $urandom;
      stage[12] = $urandom;
      stage[13] = {29'd0, pl};
      stage[14] = vp * ht + hp;  // in vertical back porch
      for (int i = 1; i <= 14; i++) do_cycle(1'b1, i, stage[i]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      int unused_seed;
      unused_seed = $urandom(32'd20250311);
      for (int i = 0; i <= 14; i++) begin prog[i] = 0; live[i] = 0; end
      men = 0; mf = 0; mh = 0; mline = 0; mframe = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: outputs idle, all registers zero (R10 R11)
      phase = "R10 reset";
      run(20);

      // directed: no window, fetch enabled, plain polarity
      phase = "directed A";
      program_set(2, 2, 4, 2, 1, 1, 3, 1, 0, 4, 3, 3'b000, 1'b1);
      do_cycle(1'b1, 0, 32'd1);
      run(2 * 60 + 13);

      // change timing mid-frame: old frame must finish unchanged (R9)
      phase = "R9 mid-frame rewrite";
      program_set(1, 3, 6, 2, 2, 1, 4, 2, 1, 4, 2, 3'b111, 1'b1);
      run(3 * 12 * 9 + 5);

      // random sets, each started from a stopped engine
      for (int k = 0; k < 6; k++) begin
         int hp, hbp, w, fp, vp, vbp, hgt, vfp, skew, xres, yres;
         phase = "R10 stopped";
         do_cycle(1'b1, 0, 32'd0);
         run(6);
         hp = 1 + $urandom % 3; hbp = 1 + $urandom % 3;
         w = 2 + $urandom % 7;  fp = 1 + $urandom % 3;
         vp = 1 + $urandom % 2; vbp = 1 + $urandom % 2;
         hgt = 2 + $urandom % 4; vfp = 1 + $urandom % 2;
         skew = $urandom % 3;
         xres = ($urandom % 2) ? w : 1 + $urandom % (w - 1);
         yres = ($urandom % 2) ? hgt : 1 + $urandom % (hgt - 1);
         phase = "R4 random set";
         program_set(hp, hbp, w, fp, vp, vbp, hgt, vfp, skew, xres, yres,
                     3'($urandom), 1'($urandom));
         do_cycle(1'b1, 0, 32'd1);
         run(2 * (hp + hbp + w + fp) * (vp + vbp + hgt + vfp) + 9);
      end

      // stop mid-frame: counters read zero, outputs idle (R8 R10)
      phase = "R10 stop mid-frame";
      do_cycle(1'b1, 0, 32'd0);
      run(40);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule